// File: doc/BRIEF.md
# Proximity Card Session Controller

This block is the card-side protocol controller of a proximity card. It consumes frames that an upstream receiver has already demodulated, checked and decoded into a command code, an argument word and a block address. It steps a card through its session. The card starts in standby and is woken by a request. It then reports its serial number during anticollision and becomes selected when the reader names that serial number. Next comes a three-pass challenge and response keyed to one block address. After that it issues memory command strobes to a downstream memory unit. Every answer is a registered response frame. Cipher, CRC, modulation and the non-volatile array are outside the block.

The controller has five states. STANDBY is the power-up and fallback state. READY is entered after a request has been answered. ACTIVE means the card is selected. CHALLENGE means a challenge has been sent and the token is awaited. AUTHENTICATED means memory commands are accepted. The transitions are as follows. Wake (STANDBY to READY on a request). Select (READY to ACTIVE on a matching serial). Deselect (READY to STANDBY on a foreign serial). Issue challenge (ACTIVE or AUTHENTICATED to CHALLENGE on an authentication request). Verify (CHALLENGE to AUTHENTICATED on a good token). Reject (CHALLENGE to STANDBY on a bad token or any other frame). Premature access (ACTIVE to STANDBY on a memory command). Foreign sector (AUTHENTICATED to STANDBY on a memory command outside the authenticated sector). Halt and field loss (any state to STANDBY). The random challenge comes from a free-running 16-bit LFSR.

Top module: `prox_card_ctrl`

## Requirements
- R1: After reset the card is in STANDBY with `selected`, `authed`, `rsp_valid` and `mem_req` low. In STANDBY every frame except a request (code 0x26) is ignored with no response. A request answers with response code 0x04 and moves to READY.
- R2: In READY an anticollision frame (code 0x93) answers with code 0x10 and `rsp_data` = {serial[31:0], check byte}, where the check byte is the XOR of the four serial bytes. A repeated request in READY answers 0x04 again.
- R3: In READY a select frame (code 0x70) whose `frame_arg[31:0]` equals the card serial raises `selected` and answers with the type code 0x08. A select with any other serial returns the card to STANDBY with no response.
- R4: When selected, an authentication frame (code 0x60) records `frame_blk` and answers with code 0x20 and the challenge RB in `rsp_data[15:0]`. RB is nonzero and two challenges issued at different times differ.
- R5: In CHALLENGE a token frame (code 0xA5) with `frame_arg[47:32]` = RA, `frame_arg[31:16]` = RB and `frame_arg[15:0]` = serial[15:0] raises `authed`. It answers with code 0x21 and `rsp_data[31:16]` = RB, `rsp_data[15:0]` = RA.
- R6: A token with a wrong RB or a wrong identifier, or any non-token frame in CHALLENGE, returns the card to STANDBY with no response and both flags low.
- R7: A memory command received while selected but not authenticated gives no strobe and returns the card to STANDBY.
- R8: When authenticated, a memory command whose block lies in the authenticated sector (same `frame_blk[5:2]`) pulses `mem_req` for one cycle with `mem_blk` = `frame_blk`. It answers with code 0x0A. The `mem_op` values are READ (0x30) = 0, WRITE (0xA0) = 1, INCREMENT (0xC1) = 2, DECREMENT (0xC0) = 3, TRANSFER (0xB0) = 4 and RESTORE (0xC2) = 5.
- R9: When authenticated, a memory command outside the authenticated sector gives no strobe and returns the card to STANDBY.
- R10: Block 0 is read-only. Any memory command other than READ aimed at it answers with code 0x05 and gives no strobe, and the card stays authenticated. A READ of block 0 is strobed normally.
- R11: A halt frame (code 0x50) in any state, or `field_on` low in any cycle, returns the card to STANDBY with both flags low from the next cycle.
- R12: Each response and strobe appears in the cycle after the clock edge that samples the frame and lasts one cycle. No response or strobe appears without a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_on | input | 1 | Carrier present; low forces standby |
| frame_valid | input | 1 | One-cycle strobe for a decoded reader frame |
| frame_cmd | input | 8 | Command code of the frame |
| frame_arg | input | 48 | Serial number or token argument |
| frame_blk | input | 6 | Block address carried by the frame |
| rsp_valid | output | 1 | One-cycle strobe for a response frame |
| rsp_code | output | 8 | Response code |
| rsp_data | output | 40 | Response payload |
| selected | output | 1 | Card is selected |
| authed | output | 1 | Card is authenticated |
| mem_req | output | 1 | One-cycle memory command strobe |
| mem_op | output | 3 | Memory operation code |
| mem_blk | output | 6 | Memory block address |

## Verification
The bench keeps the default 16-bit nonce, 64 blocks and four blocks per sector. It overrides the serial with 0x5A3C91E2, whose check byte 0x15 is not trivial. The low half of that serial differs from both nonce fields, so a token that swaps the identifier with RB is caught. With four-block sectors, blocks 5 and 6 share a sector while block 9 does not, and sector 0 holds the read-only block 0. This keeps the foreign-sector and read-only paths within a few frames of one authentication.

// File: rtl/prox_pkg.sv
package prox_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_READY,
        ST_ACTIVE,
        ST_CHALLENGE,
        ST_AUTHENTICATED
    } card_state_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_WAKE,
        K_ANTI,
        K_SELECT,
        K_AUTH,
        K_TOKEN,
        K_HALT,
        K_MEM
    } frame_kind_t;

    typedef enum logic [2:0] {
        OP_READ     = 3'd0,
        OP_WRITE    = 3'd1,
        OP_INC      = 3'd2,
        OP_DEC      = 3'd3,
        OP_TRANSFER = 3'd4,
        OP_RESTORE  = 3'd5
    } mem_op_t;

    localparam logic [7:0] CMD_WAKE     = 8'h26;
    localparam logic [7:0] CMD_ANTI     = 8'h93;
    localparam logic [7:0] CMD_SELECT   = 8'h70;
    localparam logic [7:0] CMD_AUTH     = 8'h60;
    localparam logic [7:0] CMD_TOKEN    = 8'hA5;
    localparam logic [7:0] CMD_HALT     = 8'h50;
    localparam logic [7:0] CMD_READ     = 8'h30;
    localparam logic [7:0] CMD_WRITE    = 8'hA0;
    localparam logic [7:0] CMD_INC      = 8'hC1;
    localparam logic [7:0] CMD_DEC      = 8'hC0;
    localparam logic [7:0] CMD_TRANSFER = 8'hB0;
    localparam logic [7:0] CMD_RESTORE  = 8'hC2;

    localparam logic [7:0] RSP_WAKE  = 8'h04;
    localparam logic [7:0] RSP_UID   = 8'h10;
    localparam logic [7:0] RSP_CHAL  = 8'h20;
    localparam logic [7:0] RSP_TOKEN = 8'h21;
    localparam logic [7:0] RSP_ACK   = 8'h0A;
    localparam logic [7:0] RSP_NAK   = 8'h05;

    localparam int SERIAL_W = 32;

    function automatic logic [7:0] serial_check(input logic [SERIAL_W-1:0] s);
        logic [7:0] acc;
        acc = '0;
        for (int i = 0; i < SERIAL_W / 8; i++) begin
            acc = acc ^ s[i*8 +: 8];
        end
        return acc;
    endfunction

endpackage

// File: rtl/prox_lfsr.sv
module prox_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] value
);
    localparam logic [WIDTH-1:0] TAP_MASK = WIDTH'(TAPS);
    localparam logic [WIDTH-1:0] SEED_V   = WIDTH'(SEED);

    logic [WIDTH-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEED_V;
        end else if (q[0]) begin
            q <= (q >> 1) ^ TAP_MASK;
        end else begin
            q <= q >> 1;
        end
    end

    assign value = q;
endmodule

// File: rtl/prox_cmd_decode.sv
module prox_cmd_decode
    import prox_pkg::*;
(
    input  logic [7:0]  cmd,
    output frame_kind_t kind,
    output mem_op_t     op
);
    always_comb begin
        kind = K_MEM;
        op   = OP_READ;
        case (cmd)
            CMD_WAKE:     kind = K_WAKE;
            CMD_ANTI:     kind = K_ANTI;
            CMD_SELECT:   kind = K_SELECT;
            CMD_AUTH:     kind = K_AUTH;
            CMD_TOKEN:    kind = K_TOKEN;
            CMD_HALT:     kind = K_HALT;
            CMD_READ:     op   = OP_READ;
            CMD_WRITE:    op   = OP_WRITE;
            CMD_INC:      op   = OP_INC;
            CMD_DEC:      op   = OP_DEC;
            CMD_TRANSFER: op   = OP_TRANSFER;
            CMD_RESTORE:  op   = OP_RESTORE;
            default:      kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/prox_sector_guard.sv
module prox_sector_guard
    import prox_pkg::*;
#(
    parameter int BLK_W = 6,
    parameter int SEC_W = 2
) (
    input  logic [BLK_W-1:0] req_blk,
    input  logic [BLK_W-1:0] auth_blk,
    input  mem_op_t          op,
    output logic             same_sector,
    output logic             ro_hit
);
    localparam int SECTOR_BITS = BLK_W - SEC_W;

    logic [SECTOR_BITS-1:0] req_sec;
    logic [SECTOR_BITS-1:0] auth_sec;

    assign req_sec     = req_blk[BLK_W-1:SEC_W];
    assign auth_sec    = auth_blk[BLK_W-1:SEC_W];
    assign same_sector = (req_sec == auth_sec);
    assign ro_hit      = (req_blk == '0) && (op != OP_READ);
endmodule

// File: rtl/prox_card_ctrl.sv
module prox_card_ctrl
    import prox_pkg::*;
#(
    parameter logic [31:0] SERIAL_ID  = 32'hC0FFEE12,
    parameter logic [7:0]  TYPE_CODE  = 8'h08,
    parameter int          NONCE_W    = 16,
    parameter logic [15:0] NONCE_SEED = 16'hACE1,
    parameter int          BLK_W      = 6,
    parameter int          SEC_W      = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   field_on,
    input  logic                   frame_valid,
    input  logic [7:0]             frame_cmd,
    input  logic [3*NONCE_W-1:0]   frame_arg,
    input  logic [BLK_W-1:0]       frame_blk,
    output logic                   rsp_valid,
    output logic [7:0]             rsp_code,
    output logic [SERIAL_W+7:0]    rsp_data,
    output logic                   selected,
    output logic                   authed,
    output logic                   mem_req,
    output logic [2:0]             mem_op,
    output logic [BLK_W-1:0]       mem_blk
);
    localparam int RSP_W = SERIAL_W + 8;

    card_state_t          state, state_n;
    logic [NONCE_W-1:0]   chal_q;
    logic [BLK_W-1:0]     auth_blk_q;
    logic                 chal_ld;

    logic [NONCE_W-1:0]   rnd;
    frame_kind_t          kind;
    mem_op_t              op;
    logic                 same_sector;
    logic                 ro_hit;

    logic                 rv_n;
    logic [7:0]           rc_n;
    logic [RSP_W-1:0]     rd_n;
    logic                 mr_n;

    logic [NONCE_W-1:0]   tok_ra;
    logic [NONCE_W-1:0]   tok_rb;
    logic [NONCE_W-1:0]   tok_id;
    logic                 token_ok;
    logic                 serial_hit;

    prox_lfsr #(
        .WIDTH (NONCE_W),
        .SEED  (NONCE_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    prox_cmd_decode u_dec (
        .cmd  (frame_cmd),
        .kind (kind),
        .op   (op)
    );

    prox_sector_guard #(
        .BLK_W (BLK_W),
        .SEC_W (SEC_W)
    ) u_guard (
        .req_blk     (frame_blk),
        .auth_blk    (auth_blk_q),
        .op          (op),
        .same_sector (same_sector),
        .ro_hit      (ro_hit)
    );

    assign tok_ra     = frame_arg[3*NONCE_W-1:2*NONCE_W];
    assign tok_rb     = frame_arg[2*NONCE_W-1:NONCE_W];
    assign tok_id     = frame_arg[NONCE_W-1:0];
    assign token_ok   = (tok_rb == chal_q) && (tok_id == SERIAL_ID[NONCE_W-1:0]);
    assign serial_hit = (frame_arg[SERIAL_W-1:0] == SERIAL_ID);

    // Next-state and next-output decision
    always_comb begin
        state_n = state;
        rv_n    = 1'b0;
        rc_n    = '0;
        rd_n    = '0;
        mr_n    = 1'b0;
        chal_ld = 1'b0;
        if (!field_on) begin
            state_n = ST_STANDBY;
        end else if (frame_valid) begin
            if (kind == K_HALT) begin
                state_n = ST_STANDBY;
            end else begin
                unique case (state)
                    ST_STANDBY: begin
                        if (kind == K_WAKE) begin
                            state_n = ST_READY;
                            rv_n    = 1'b1;
                            rc_n    = RSP_WAKE;
                        end
                    end
                    ST_READY: begin
                        if (kind == K_WAKE) begin
                            rv_n = 1'b1;
                            rc_n = RSP_WAKE;
                        end else if (kind == K_ANTI) begin
                            rv_n = 1'b1;
                            rc_n = RSP_UID;
                            rd_n = {SERIAL_ID, serial_check(SERIAL_ID)};
                        end else if (kind == K_SELECT) begin
                            if (serial_hit) begin
                                state_n = ST_ACTIVE;
                                rv_n    = 1'b1;
                                rc_n    = TYPE_CODE;
                            end else begin
                                state_n = ST_STANDBY;
                            end
                        end
                    end
                    ST_ACTIVE: begin
                        if (kind == K_AUTH) begin
                            state_n = ST_CHALLENGE;
                            chal_ld = 1'b1;
                            rv_n    = 1'b1;
                            rc_n    = RSP_CHAL;
                            rd_n[NONCE_W-1:0] = rnd;
                        end else if (kind == K_MEM) begin
                            state_n = ST_STANDBY;
                        end
                    end
                    ST_CHALLENGE: begin
                        if (kind == K_TOKEN && token_ok) begin
                            state_n = ST_AUTHENTICATED;
                            rv_n    = 1'b1;
                            rc_n    = RSP_TOKEN;
                            rd_n[2*NONCE_W-1:0] = {chal_q, tok_ra};
                        end else begin
                            state_n = ST_STANDBY;
                        end
                    end
                    ST_AUTHENTICATED: begin
                        if (kind == K_AUTH) begin
                            state_n = ST_CHALLENGE;
                            chal_ld = 1'b1;
                            rv_n    = 1'b1;
                            rc_n    = RSP_CHAL;
                            rd_n[NONCE_W-1:0] = rnd;
                        end else if (kind == K_MEM) begin
                            if (!same_sector) begin
                                state_n = ST_STANDBY;
                            end else if (ro_hit) begin
                                rv_n = 1'b1;
                                rc_n = RSP_NAK;
                            end else begin
                                mr_n = 1'b1;
                                rv_n = 1'b1;
                                rc_n = RSP_ACK;
                            end
                        end
                    end
                    default: state_n = ST_STANDBY;
                endcase
            end
        end
    end

    // State register with session context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_STANDBY;
            chal_q     <= '0;
            auth_blk_q <= '0;
        end else begin
            state <= state_n;
            if (chal_ld) begin
                chal_q     <= rnd;
                auth_blk_q <= frame_blk;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= '0;
            rsp_data  <= '0;
            selected  <= 1'b0;
            authed    <= 1'b0;
            mem_req   <= 1'b0;
            mem_op    <= '0;
            mem_blk   <= '0;
        end else begin
            rsp_valid <= rv_n;
            rsp_code  <= rc_n;
            rsp_data  <= rd_n;
            selected  <= (state_n == ST_ACTIVE) || (state_n == ST_CHALLENGE) ||
                         (state_n == ST_AUTHENTICATED);
            authed    <= (state_n == ST_AUTHENTICATED);
            mem_req   <= mr_n;
            mem_op    <= op;
            mem_blk   <= frame_blk;
        end
    end
endmodule

// File: rtl/prox_card_chk.sv
module prox_card_chk
    import prox_pkg::*;
#(
    parameter logic [7:0] TYPE_CODE = 8'h08,
    parameter int         BLK_W     = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               field_on,
    input logic               frame_valid,
    input logic [7:0]         frame_cmd,
    input logic               rsp_valid,
    input logic [7:0]         rsp_code,
    input logic [SERIAL_W+7:0] rsp_data,
    input logic               selected,
    input logic               authed,
    input logic               mem_req,
    input logic [2:0]         mem_op,
    input logic [BLK_W-1:0]   mem_blk
);
    a_r5_auth_implies_select: assert property (@(posedge clk) disable iff (!rst_n)
        authed |-> selected);

    a_r8_strobe_needs_auth: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> authed);

    a_r3_type_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == TYPE_CODE) |-> selected);

    a_r2_check_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_UID) |->
            rsp_data[7:0] == serial_check(rsp_data[SERIAL_W+7:8]));

    a_r10_block0_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_blk == '0) |-> mem_op == 3'(OP_READ));

    a_r11_field_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !field_on |=> (!selected && !authed && !rsp_valid && !mem_req));

    a_r11_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_cmd == CMD_HALT) |=> (!selected && !authed));

    a_r12_no_spontaneous: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> (!rsp_valid && !mem_req));
endmodule

bind prox_card_ctrl prox_card_chk #(
    .TYPE_CODE (TYPE_CODE),
    .BLK_W     (BLK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_on    (field_on),
    .frame_valid (frame_valid),
    .frame_cmd   (frame_cmd),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .rsp_data    (rsp_data),
    .selected    (selected),
    .authed      (authed),
    .mem_req     (mem_req),
    .mem_op      (mem_op),
    .mem_blk     (mem_blk)
);

// File: tb/prox_card_ctrl_test.sv
module prox_card_ctrl_test;
    localparam logic [31:0] SER = 32'h5A3C91E2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        field_on = 1'b1;
    logic        frame_valid = 1'b0;
    logic [7:0]  frame_cmd = '0;
    logic [47:0] frame_arg = '0;
    logic [5:0]  frame_blk = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_code;
    logic [39:0] rsp_data;
    logic        selected;
    logic        authed;
    logic        mem_req;
    logic [2:0]  mem_op;
    logic [5:0]  mem_blk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prox_card_ctrl #(.SERIAL_ID(SER)) uut (
        .clk(clk), .rst_n(rst_n), .field_on(field_on),
        .frame_valid(frame_valid), .frame_cmd(frame_cmd),
        .frame_arg(frame_arg), .frame_blk(frame_blk),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
        .selected(selected), .authed(authed), .mem_req(mem_req),
        .mem_op(mem_op), .mem_blk(mem_blk)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] cmd, input logic [47:0] arg, input logic [5:0] blk);
        @(negedge clk);
        frame_valid = 1'b1;
        frame_cmd   = cmd;
        frame_arg   = arg;
        frame_blk   = blk;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    function automatic logic [7:0] cb(input logic [31:0] s);
        return s[31:24] ^ s[23:16] ^ s[15:8] ^ s[7:0];
    endfunction

    task automatic to_selected();
        send(8'h50, '0, '0);
        send(8'h26, '0, '0);
        send(8'h70, {16'h0, SER}, '0);
    endtask

    task automatic to_authed(input logic [5:0] blk, output logic [15:0] rb);
        to_selected();
        send(8'h60, '0, blk);
        rb = rsp_data[15:0];
        send(8'hA5, {16'h1234, rb, SER[15:0]}, '0);
    endtask

    task automatic t_reset();
        check(selected, 0, "R1 selected after reset");
        check(authed, 0, "R1 authed after reset");
        check(rsp_valid, 0, "R1 rsp_valid after reset");
        check(mem_req, 0, "R1 mem_req after reset");
    endtask

    task automatic t_standby_ignore();
        send(8'h93, '0, '0);
        check(rsp_valid, 0, "R1 anticollision ignored in standby");
        send(8'h70, {16'h0, SER}, '0);
        check({rsp_valid, selected}, 0, "R1 select ignored in standby");
        send(8'h26, '0, '0);
        check({rsp_valid, rsp_code}, {1'b1, 8'h04}, "R1 request answer");
    endtask

    task automatic t_anticoll();
        send(8'h93, '0, '0);
        check({rsp_valid, rsp_code}, {1'b1, 8'h10}, "R2 anticollision code");
        check(rsp_data, {SER, cb(SER)}, "R2 serial and check byte");
        @(negedge clk);
        check(rsp_valid, 0, "R12 response lasts one cycle");
        send(8'h26, '0, '0);
        check({rsp_valid, rsp_code}, {1'b1, 8'h04}, "R2 repeated request");
    endtask

    task automatic t_select();
        send(8'h70, {16'h0, SER ^ 32'h1}, '0);
        check({rsp_valid, selected}, 0, "R3 foreign serial no answer");
        send(8'h93, '0, '0);
        check(rsp_valid, 0, "R3 foreign serial back to standby");
        send(8'h26, '0, '0);
        send(8'h70, {16'h0, SER}, '0);
        check({rsp_valid, rsp_code, selected}, {1'b1, 8'h08, 1'b1}, "R3 select type code");
    endtask

    task automatic t_mem_before_auth();
        to_selected();
        send(8'h30, '0, 6'd5);
        check({mem_req, selected, authed}, 0, "R7 memory before auth");
    endtask

    task automatic t_auth_pass();
        logic [15:0] rb1;
        logic [15:0] rb2;
        to_selected();
        send(8'h60, '0, 6'd6);
        check({rsp_valid, rsp_code}, {1'b1, 8'h20}, "R4 challenge code");
        rb1 = rsp_data[15:0];
        check(rb1 != 0, 1, "R4 challenge nonzero");
        send(8'hA5, {16'hBEEF, rb1, SER[15:0]}, '0);
        check({rsp_valid, rsp_code, authed}, {1'b1, 8'h21, 1'b1}, "R5 token accepted");
        check(rsp_data[31:0], {rb1, 16'hBEEF}, "R5 token reply");
        repeat (3) @(negedge clk);
        send(8'h60, '0, 6'd6);
        rb2 = rsp_data[15:0];
        check(rb2 != rb1, 1, "R4 challenges differ");
        send(8'hA5, {16'h0102, rb2, SER[15:0]}, '0);
        check(authed, 1, "R5 re-authentication");
    endtask

    task automatic t_mem_ops();
        logic [7:0] codes [6] = '{8'h30, 8'hA0, 8'hC1, 8'hC0, 8'hB0, 8'hC2};
        for (int i = 0; i < 6; i++) begin
            send(codes[i], '0, 6'd5);
            check({mem_req, mem_op, mem_blk, rsp_valid, rsp_code},
                  {1'b1, 3'(i), 6'd5, 1'b1, 8'h0A}, "R8 strobe in sector");
            @(negedge clk);
            check(mem_req, 0, "R12 strobe lasts one cycle");
        end
    endtask

    task automatic t_other_sector();
        send(8'h30, '0, 6'd9);
        check({mem_req, selected, authed}, 0, "R9 foreign sector");
    endtask

    task automatic t_token_fail();
        logic [15:0] rb;
        to_selected();
        send(8'h60, '0, 6'd6);
        rb = rsp_data[15:0];
        send(8'hA5, {16'h1111, rb ^ 16'h8, SER[15:0]}, '0);
        check({rsp_valid, selected, authed}, 0, "R6 wrong RB");
        to_selected();
        send(8'h60, '0, 6'd6);
        rb = rsp_data[15:0];
        send(8'hA5, {16'h1111, SER[15:0], rb}, '0);
        check({rsp_valid, selected, authed}, 0, "R6 wrong identifier");
        to_selected();
        send(8'h60, '0, 6'd6);
        send(8'h30, '0, 6'd6);
        check({rsp_valid, mem_req, selected}, 0, "R6 non-token in challenge");
    endtask

    task automatic t_block0();
        logic [15:0] rb;
        to_authed(6'd1, rb);
        check(authed, 1, "R10 authed in sector 0");
        send(8'hA0, '0, 6'd0);
        check({mem_req, rsp_valid, rsp_code, authed}, {1'b0, 1'b1, 8'h05, 1'b1}, "R10 write block 0 refused");
        send(8'hC1, '0, 6'd0);
        check({mem_req, rsp_code}, {1'b0, 8'h05}, "R10 increment block 0 refused");
        send(8'h30, '0, 6'd0);
        check({mem_req, mem_op, mem_blk}, {1'b1, 3'd0, 6'd0}, "R10 read block 0");
    endtask

    task automatic t_halt_field();
        logic [15:0] rb;
        to_authed(6'd6, rb);
        send(8'h50, '0, '0);
        check({selected, authed}, 0, "R11 halt");
        send(8'h93, '0, '0);
        check(rsp_valid, 0, "R11 standby after halt");
        to_authed(6'd6, rb);
        @(negedge clk);
        field_on = 1'b0;
        @(negedge clk);
        field_on = 1'b1;
        check({selected, authed}, 0, "R11 field loss");
        send(8'h30, '0, 6'd6);
        check(mem_req, 0, "R11 no strobe after field loss");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_standby_ignore();
        t_anticoll();
        t_select();
        t_mem_before_auth();
        t_auth_pass();
        t_mem_ops();
        t_other_sector();
        t_token_fail();
        t_block0();
        t_halt_field();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule